// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block turns a 16-bit processor address into a memory target. It uses the live configuration byte, the video bank select, the shared-RAM controls and two page relocation pointers. Each address goes to one of six places: banked RAM (with an 18-bit physical address), the system ROM, the internal function ROM, the external function ROM, the I/O space, or the register window of the memory manager itself. The block also reports which RAM bank the video controller reads from.

The decode is a single combinational cone. One register stage follows it, so a result appears on the clock edge after its inputs are applied. The configuration byte splits the upper 48 KiB into three regions, and each region has its own field. A separate bit places I/O over D000–DFFF. A shared window at the top or bottom of the map can force accesses to bank 0. The two pointers swap processor pages 0 and 1 with any physical page, so no RAM is lost. A parameter limits the system to two physical banks, and in that case bank selects 2 and 3 fold onto 0 and 1.

Top module: `mmu_bank_decoder`

## Requirements
- R1: The target code on `tgt` is 0 RAM, 1 system ROM, 2 internal function ROM, 3 external function ROM, 4 I/O, 5 manager registers. All outputs are registered and change on the rising edge after the inputs. While `rst_n` is low, `tgt`, `ram_phys` and `vid_bank` are 0.
- R2: Addresses 0000–3FFF always decode to RAM.
- R3: For 4000–7FFF, configuration bit 1 at 0 selects system ROM and at 1 selects RAM.
- R4: For 8000–BFFF, configuration bits 3:2 select 00 system ROM, 01 internal function ROM, 10 external function ROM, 11 RAM.
- R5: For C000–FFFF, configuration bits 5:4 use the same four-way code as R4. When configuration bit 0 is 0, D000–DFFF decodes to I/O and this overrides the region field.
- R6: FF00–FF04 decode to the manager registers in every configuration unless `compat` is 1. With `compat` at 1, these addresses decode as R5 says.
- R7: Configuration bits 7:6 pick the RAM bank. With NUM_BANKS = 2, only bit 6 counts, so 2 maps to 0 and 3 maps to 1. `ram_phys` is {bank[1:0], address[15:0]} for a RAM target and 0 for any other target.
- R8: `vid_bank` follows `vid_sel` and uses the same bank folding as R7. It is independent of the configuration byte.
- R9: `share_en[0]` enables a shared window at the bottom of the map, and `share_en[1]` enables one at the top. `share_size` gives the window size: 00 1 KiB, 01 4 KiB, 10 8 KiB, 11 16 KiB. A RAM access inside an enabled window uses bank 0. Manager, I/O and ROM decodes still take priority.
- R10: RAM page 00 maps to physical page {`pg0_bank`, `pg0_page`}, and RAM page 01 maps to {`pg1_bank`, `pg1_page`}. Pointer banks fold as in R7. A RAM access to the page that pointer 0 names, in that pointer's bank, goes to bank 0 page 00. Likewise, an access to pointer 1's page goes to bank 0 page 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cfg | input | 8 | Live configuration byte |
| vid_sel | input | 2 | Video bank select |
| share_en | input | 2 | Shared window enables: bit 0 bottom, bit 1 top |
| share_size | input | 2 | Shared window size code |
| pg0_page | input | 8 | Physical page for processor page 00 |
| pg0_bank | input | 2 | Bank for processor page 00 |
| pg1_page | input | 8 | Physical page for processor page 01 |
| pg1_bank | input | 2 | Bank for processor page 01 |
| compat | input | 1 | Compatibility mode; hides the register window |
| tgt | output | 3 | Target code |
| ram_phys | output | 18 | Physical RAM address |
| vid_bank | output | 2 | Bank seen by the video controller |

## Verification
The bench probes both edges of every shared-window size. A wrong size or comparison would move one byte into the wrong bank. It checks FF04 and FF05, and the window with `compat` set. A wrong window would either hide RAM or expose the registers when it should not. It runs the I/O bit against RAM and ROM high-region settings. A wrong overlay priority would show RAM or ROM where I/O belongs. It exercises the page swap in both directions and with a folded pointer bank. A one-way relocation would let pointed-to pages alias page 0 and lose memory.

// File: rtl/mmu_dec_pkg.sv
package mmu_dec_pkg;

    typedef enum logic [2:0] {
        TGT_RAM    = 3'd0,
        TGT_SYSROM = 3'd1,
        TGT_IFROM  = 3'd2,
        TGT_EFROM  = 3'd3,
        TGT_IO     = 3'd4,
        TGT_MMU    = 3'd5
    } tgt_e;

    localparam int ADDR_W  = 16;
    localparam int BANK_W  = 2;
    localparam int PHYS_W  = ADDR_W + BANK_W;
    localparam int PAGE_W  = 8;

    localparam logic [15:0] REG_WIN_LO = 16'hFF00;
    localparam logic [15:0] REG_WIN_HI = 16'hFF04;
    localparam logic [3:0]  IO_NIBBLE  = 4'hD;

    typedef struct packed {
        tgt_e               tgt;
        logic [PHYS_W-1:0]  phys;
        logic [BANK_W-1:0]  vid;
    } dec_out_t;

    // Four-way region field: 00 sys ROM, 01 int ROM, 10 ext ROM, 11 RAM
    function automatic tgt_e field_target(input logic [1:0] f);
        tgt_e t;
        unique case (f)
            2'b00:   t = TGT_SYSROM;
            2'b01:   t = TGT_IFROM;
            2'b10:   t = TGT_EFROM;
            default: t = TGT_RAM;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/bank_fold.sv
module bank_fold
    import mmu_dec_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic [BANK_W-1:0] raw_bank,
    output logic [BANK_W-1:0] eff_bank
);
    localparam logic [BANK_W-1:0] FOLD_MASK =
        (NUM_BANKS <= 2) ? BANK_W'(1) : {BANK_W{1'b1}};

    always_comb begin
        eff_bank = raw_bank & FOLD_MASK;
    end
endmodule

// File: rtl/region_select.sv
module region_select
    import mmu_dec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [5:0]        region_cfg,
    input  logic              compat,
    output tgt_e              tgt
);
    logic in_reg_win;
    logic in_io;
    tgt_e base_tgt;

    always_comb begin
        unique case (addr[15:14])
            2'b00:   base_tgt = TGT_RAM;
            2'b01:   base_tgt = region_cfg[1] ? TGT_RAM : TGT_SYSROM;
            2'b10:   base_tgt = field_target(region_cfg[3:2]);
            default: base_tgt = field_target(region_cfg[5:4]);
        endcase
    end

    always_comb begin
        in_reg_win = !compat && (addr >= REG_WIN_LO) && (addr <= REG_WIN_HI);
        in_io      = !region_cfg[0] && (addr[15:12] == IO_NIBBLE);
    end

    always_comb begin
        if (in_reg_win) begin
            tgt = TGT_MMU;
        end else if (in_io) begin
            tgt = TGT_IO;
        end else begin
            tgt = base_tgt;
        end
    end
endmodule

// File: rtl/ram_mapper.sv
module ram_mapper
    import mmu_dec_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] sel_bank,
    input  logic [1:0]        share_en,
    input  logic [1:0]        share_size,
    input  logic [PAGE_W-1:0] pg0_page,
    input  logic [BANK_W-1:0] pg0_bank,
    input  logic [PAGE_W-1:0] pg1_page,
    input  logic [BANK_W-1:0] pg1_bank,
    output logic [PHYS_W-1:0] phys
);
    localparam int LEN_W = ADDR_W + 1;

    logic [LEN_W-1:0]  share_len;
    logic [LEN_W-1:0]  top_base;
    logic              in_bot;
    logic              in_top;
    logic [BANK_W-1:0] acc_bank;
    logic [BANK_W-1:0] p0_bank_f;
    logic [BANK_W-1:0] p1_bank_f;
    logic [PAGE_W-1:0] cpu_page;

    bank_fold #(.NUM_BANKS(NUM_BANKS)) i_fold_p0 (
        .raw_bank (pg0_bank),
        .eff_bank (p0_bank_f)
    );

    bank_fold #(.NUM_BANKS(NUM_BANKS)) i_fold_p1 (
        .raw_bank (pg1_bank),
        .eff_bank (p1_bank_f)
    );

    always_comb begin
        unique case (share_size)
            2'b00:   share_len = LEN_W'(17'h00400);
            2'b01:   share_len = LEN_W'(17'h01000);
            2'b10:   share_len = LEN_W'(17'h02000);
            default: share_len = LEN_W'(17'h04000);
        endcase
        top_base = LEN_W'(17'h10000) - share_len;
        in_bot   = share_en[0] && ({1'b0, addr} < share_len);
        in_top   = share_en[1] && ({1'b0, addr} >= top_base);
        acc_bank = (in_bot || in_top) ? '0 : sel_bank;
    end

    always_comb begin
        cpu_page = addr[15:8];
        if (cpu_page == 8'h00) begin
            phys = {p0_bank_f, pg0_page, addr[7:0]};
        end else if (cpu_page == 8'h01) begin
            phys = {p1_bank_f, pg1_page, addr[7:0]};
        end else if ((acc_bank == p0_bank_f) && (cpu_page == pg0_page)) begin
            phys = {{BANK_W{1'b0}}, 8'h00, addr[7:0]};
        end else if ((acc_bank == p1_bank_f) && (cpu_page == pg1_page)) begin
            phys = {{BANK_W{1'b0}}, 8'h01, addr[7:0]};
        end else begin
            phys = {acc_bank, addr};
        end
    end
endmodule

// File: rtl/mmu_bank_decoder.sv
module mmu_bank_decoder
    import mmu_dec_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cfg,
    input  logic [1:0]  vid_sel,
    input  logic [1:0]  share_en,
    input  logic [1:0]  share_size,
    input  logic [7:0]  pg0_page,
    input  logic [1:0]  pg0_bank,
    input  logic [7:0]  pg1_page,
    input  logic [1:0]  pg1_bank,
    input  logic        compat,
    output logic [2:0]  tgt,
    output logic [17:0] ram_phys,
    output logic [1:0]  vid_bank
);
    tgt_e              reg_tgt;
    logic [BANK_W-1:0] cpu_bank_f;
    logic [BANK_W-1:0] vid_bank_f;
    logic [PHYS_W-1:0] mapped_phys;
    dec_out_t          out_d;
    dec_out_t          out_q;

    bank_fold #(.NUM_BANKS(NUM_BANKS)) i_fold_cpu (
        .raw_bank (cfg[7:6]),
        .eff_bank (cpu_bank_f)
    );

    bank_fold #(.NUM_BANKS(NUM_BANKS)) i_fold_vid (
        .raw_bank (vid_sel),
        .eff_bank (vid_bank_f)
    );

    region_select i_region (
        .addr       (cpu_addr),
        .region_cfg (cfg[5:0]),
        .compat     (compat),
        .tgt        (reg_tgt)
    );

    ram_mapper #(.NUM_BANKS(NUM_BANKS)) i_mapper (
        .addr       (cpu_addr),
        .sel_bank   (cpu_bank_f),
        .share_en   (share_en),
        .share_size (share_size),
        .pg0_page   (pg0_page),
        .pg0_bank   (pg0_bank),
        .pg1_page   (pg1_page),
        .pg1_bank   (pg1_bank),
        .phys       (mapped_phys)
    );

    always_comb begin
        out_d      = out_q;
        out_d.tgt  = reg_tgt;
        out_d.phys = (reg_tgt == TGT_RAM) ? mapped_phys : '0;
        out_d.vid  = vid_bank_f;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{tgt: TGT_RAM, phys: '0, vid: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign tgt      = out_q.tgt;
    assign ram_phys = out_q.phys;
    assign vid_bank = out_q.vid;

    // R2
    low_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |=> (out_q.tgt == TGT_RAM));

    // R6
    reg_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!compat && cpu_addr >= 16'hFF00 && cpu_addr <= 16'hFF04)
            |=> (out_q.tgt == TGT_MMU));

    // R5
    io_overlay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[0] && cpu_addr[15:12] == 4'hD) |=> (out_q.tgt == TGT_IO));

    // R7
    nonram_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.tgt != TGT_RAM) |-> (out_q.phys == '0));

    // R9
    bottom_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (share_en[0] && cpu_addr[15:10] != 6'd0 && cpu_addr[15:14] == 2'b00
         && cpu_addr[15:9] != 7'd0 && cpu_size_any_ok(cpu_addr, share_size))
            |=> (out_q.phys[17:16] == 2'b00 || out_q.phys[15:8] != $past(cpu_addr[15:8])));

    function automatic logic cpu_size_any_ok(input logic [15:0] a, input logic [1:0] s);
        logic [16:0] len;
        len = (s == 2'b00) ? 17'h00400 : (s == 2'b01) ? 17'h01000 :
              (s == 2'b10) ? 17'h02000 : 17'h04000;
        return ({1'b0, a} < len);
    endfunction

    generate
        if (NUM_BANKS <= 2) begin : g_two_bank_chk
            // R8
            vid_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                vid_sel[1] |=> !out_q.vid[1]);
            // R7
            ram_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_q.tgt == TGT_RAM) |-> !out_q.phys[17]);
        end
    endgenerate
endmodule

// File: tb/test_mmu_bank_decoder.sv
module test_mmu_bank_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cfg;
    logic [1:0]  vid_sel;
    logic [1:0]  share_en;
    logic [1:0]  share_size;
    logic [7:0]  pg0_page;
    logic [1:0]  pg0_bank;
    logic [7:0]  pg1_page;
    logic [1:0]  pg1_bank;
    logic        compat;
    logic [2:0]  tgt;
    logic [17:0] ram_phys;
    logic [1:0]  vid_bank;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [2:0] T_RAM = 3'd0, T_SYS = 3'd1, T_IFR = 3'd2,
                           T_EFR = 3'd3, T_IO = 3'd4, T_MMU = 3'd5;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_bank_decoder #(.NUM_BANKS(2)) i_mmu_bank_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cfg(cfg),
        .vid_sel(vid_sel), .share_en(share_en), .share_size(share_size),
        .pg0_page(pg0_page), .pg0_bank(pg0_bank), .pg1_page(pg1_page),
        .pg1_bank(pg1_bank), .compat(compat), .tgt(tgt),
        .ram_phys(ram_phys), .vid_bank(vid_bank)
    );

    task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic defaults();
        cpu_addr = 16'h0000; cfg = 8'h00; vid_sel = 2'b00;
        share_en = 2'b00; share_size = 2'b00;
        pg0_page = 8'h00; pg0_bank = 2'b00;
        pg1_page = 8'h01; pg1_bank = 2'b00; compat = 1'b0;
    endtask

    // drive on a falling edge, result registered on the next rising edge,
    // sampled on the falling edge after that
    task automatic probe(input logic [15:0] a, input logic [7:0] c,
                         input string req, input logic [2:0] et, input logic [17:0] ep);
        @(negedge clk);
        cpu_addr = a; cfg = c;
        @(negedge clk);
        check({req, " tgt"}, {15'd0, tgt}, {15'd0, et});
        check({req, " phys"}, ram_phys, ep);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset tgt", {15'd0, tgt}, 18'd0);
        check("R1 reset phys", ram_phys, 18'd0);
        check("R1 reset vid", {16'd0, vid_bank}, 18'd0);
    endtask

    task automatic t_low();
        probe(16'h1234, 8'h00, "R2 low bank0", T_RAM, 18'h01234);
        probe(16'h1234, 8'h40, "R2 low bank1", T_RAM, 18'h11234);
        probe(16'h3FFF, 8'h3E, "R2 top of low", T_RAM, 18'h03FFF);
        probe(16'h4567, 8'h00, "R3 sysrom", T_SYS, 18'h0);
        probe(16'h4567, 8'h02, "R3 ram", T_RAM, 18'h04567);
    endtask

    task automatic t_mid();
        probe(16'h9000, 8'h00, "R4 mid 00", T_SYS, 18'h0);
        probe(16'h9000, 8'h04, "R4 mid 01", T_IFR, 18'h0);
        probe(16'h9000, 8'h08, "R4 mid 10", T_EFR, 18'h0);
        probe(16'hBFFF, 8'h0C, "R4 mid 11", T_RAM, 18'h0BFFF);
    endtask

    task automatic t_high();
        probe(16'hC800, 8'h01, "R5 high 00", T_SYS, 18'h0);
        probe(16'hC800, 8'h11, "R5 high 01", T_IFR, 18'h0);
        probe(16'hE000, 8'h21, "R5 high 10", T_EFR, 18'h0);
        probe(16'hF000, 8'h71, "R5 high 11", T_RAM, 18'h1F000);
        probe(16'hD020, 8'h00, "R5 io over rom", T_IO, 18'h0);
        probe(16'hD020, 8'h3E, "R5 io over ram", T_IO, 18'h0);
        probe(16'hDFFF, 8'h3F, "R5 io off ram", T_RAM, 18'h0DFFF);
        probe(16'hD020, 8'h01, "R5 io off rom", T_SYS, 18'h0);
        probe(16'hCFFF, 8'h30, "R5 below io", T_RAM, 18'h0CFFF);
    endtask

    task automatic t_regwin();
        probe(16'hFF00, 8'h3F, "R6 win lo", T_MMU, 18'h0);
        probe(16'hFF04, 8'h00, "R6 win hi", T_MMU, 18'h0);
        probe(16'hFF05, 8'h3F, "R6 past win", T_RAM, 18'h0FF05);
        probe(16'hFEFF, 8'h3F, "R6 before win", T_RAM, 18'h0FEFF);
        @(negedge clk); compat = 1'b1;
        probe(16'hFF00, 8'h3F, "R6 compat ram", T_RAM, 18'h0FF00);
        probe(16'hFF02, 8'h01, "R6 compat rom", T_SYS, 18'h0);
        @(negedge clk); compat = 1'b0;
    endtask

    task automatic t_bank();
        probe(16'h8000, 8'hBF, "R7 bank2 fold", T_RAM, 18'h08000);
        probe(16'h8000, 8'hFF, "R7 bank3 fold", T_RAM, 18'h18000);
        probe(16'h8000, 8'h7F, "R7 bank1", T_RAM, 18'h18000);
    endtask

    task automatic t_video();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            vid_sel = 2'(i); cfg = 8'(i * 8'h55);
            @(negedge clk);
            check("R8 video bank", {16'd0, vid_bank}, {17'd0, 1'(i & 1)});
        end
        @(negedge clk); vid_sel = 2'b00;
    endtask

    task automatic t_share();
        @(negedge clk); share_en = 2'b01; share_size = 2'b00;
        probe(16'h03FF, 8'h7F, "R9 bot 1K in", T_RAM, 18'h003FF);
        probe(16'h0400, 8'h7F, "R9 bot 1K out", T_RAM, 18'h10400);
        @(negedge clk); share_size = 2'b01;
        probe(16'h0FFF, 8'h7F, "R9 bot 4K in", T_RAM, 18'h00FFF);
        probe(16'h1000, 8'h7F, "R9 bot 4K out", T_RAM, 18'h11000);
        @(negedge clk); share_size = 2'b11;
        probe(16'h3FFF, 8'h7F, "R9 bot 16K in", T_RAM, 18'h03FFF);
        probe(16'h4000, 8'h7F, "R9 bot 16K out", T_RAM, 18'h14000);
        @(negedge clk); share_en = 2'b10; share_size = 2'b00;
        probe(16'hFC00, 8'h7F, "R9 top 1K in", T_RAM, 18'h0FC00);
        probe(16'hFBFF, 8'h7F, "R9 top 1K out", T_RAM, 18'h1FBFF);
        probe(16'h03FF, 8'h7F, "R9 bot disabled", T_RAM, 18'h103FF);
        @(negedge clk); share_size = 2'b10;
        probe(16'hE000, 8'h7F, "R9 top 8K in", T_RAM, 18'h0E000);
        probe(16'hDFFF, 8'h7F, "R9 top 8K out", T_RAM, 18'h1DFFF);
        @(negedge clk); share_size = 2'b11;
        probe(16'hE000, 8'h40, "R9 rom wins", T_SYS, 18'h0);
        @(negedge clk); share_en = 2'b00;
        probe(16'h0210, 8'h7F, "R9 none", T_RAM, 18'h10210);
    endtask

    task automatic t_reloc();
        @(negedge clk); pg0_page = 8'h20; pg0_bank = 2'b01;
        probe(16'h0005, 8'h00, "R10 page0 out", T_RAM, 18'h12005);
        probe(16'h2005, 8'h00, "R10 other bank", T_RAM, 18'h02005);
        probe(16'h2005, 8'h40, "R10 page0 back", T_RAM, 18'h00005);
        @(negedge clk); pg1_page = 8'h33; pg1_bank = 2'b00;
        probe(16'h0177, 8'h00, "R10 page1 out", T_RAM, 18'h03377);
        probe(16'h3377, 8'h00, "R10 page1 back", T_RAM, 18'h00177);
        @(negedge clk); pg0_bank = 2'b10;
        probe(16'h0005, 8'h40, "R10 fold ptr bank", T_RAM, 18'h02005);
        @(negedge clk); defaults();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        defaults();
        rst_n = 1'b0;
        cpu_addr = 16'hD000;
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1; cpu_addr = 16'h0000;
        t_low();
        t_mid();
        t_high();
        t_regwin();
        t_bank();
        t_video();
        t_share();
        t_reloc();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule